// File: doc/BRIEF.md
# Serial Interface Status Flag Register

This block holds the status flags of a serial peripheral controller in one 32-bit word that software reads over a simple register bus. The controller core sends single-cycle event pulses for receive-full, receive overrun, bit error, desynchronisation, parity error, timeout and data-length error. Software clears each of these flags by writing a 1 to its bit. A transmit-empty flag sets when a word enters the shift register. It clears when software writes either transmit data register or writes the module enable bit to 0. Both strobes come from the neighbouring register block.

A small sequencer models the initialisation of the buffer RAM, so the read-only busy flag has real timing. It has four named states. In HELD the software-reset control is 0. In WALK it drives one RAM write per cycle. FINISH lasts one cycle and drives the done pulse. READY is idle. The transitions are: any state goes to HELD when the reset control is 0; HELD goes to WALK when the control is 1; WALK goes to FINISH on its last address; FINISH goes to READY unconditionally. A combined interrupt request is the OR of every event flag gated by its own enable bit.

Top module: `ssf_status_reg`

## Requirements
- R1: After hardware reset every event flag (bits 9, 8, 6, 4, 3, 2, 1, 0) reads 0. With the software-reset control at 0, the read word is exactly 32'h0100_0000.
- R2: Bit 24 (busy) reads 1 in the same cycle whenever `swrst_ctl` is 0, whatever the sequencer state.
- R3: When `swrst_ctl` is 1 at a clock edge with the sequencer in HELD, the next DEPTH cycles each show `ram_we`=1, with `ram_addr` stepping 0, 1, …, DEPTH-1. The cycle after that shows `init_done`=1, `ram_we`=0 and busy=1. From the following cycle on, busy reads 0.
- R4: If `swrst_ctl` drops to 0 during the walk, `ram_we` is 0 from the next cycle on. A new rise of `swrst_ctl` restarts the walk at address 0.
- R5: Each write-1-to-clear flag reads 1 in the cycle after its event pulse. The flags and their bits are: receive-full 8, overrun 6, bit error 4, desync 3, parity 2, timeout 1, data-length 0. A bus write with a 1 at the flag's bit clears it. A 0 at that bit leaves it unchanged.
- R6: If an event pulse and a write-1-to-clear of the same bit fall in one cycle, the flag reads 1 afterwards.
- R7: Bit 9 (transmit-empty) sets in the cycle after `shift_load`. It clears after `tx_data_wr`, or after `en_wr` with `en_wdata`=0. Neither `en_wr` with `en_wdata`=1 nor a bus write with bit 9 at 1 changes it.
- R8: If `shift_load` coincides with either transmit-empty clear condition, bit 9 reads 1 afterwards.
- R9: Bits 31–25, 23–10, 7 and 5 always read 0. Bus writes do not change them or bits 24 and 9.
- R10: `irq` is the OR, over bits 9, 8, 6, 4, 3, 2, 1, 0, of the flag ANDed with the same bit of `irq_en`, in the same cycle. Every other bit of `irq_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_wr | input | 1 | Write strobe for the flag register |
| bus_wdata | input | 32 | Write data (1 clears a write-1-to-clear flag) |
| bus_rdata | output | 32 | Current flag word |
| swrst_ctl | input | 1 | Module software-reset control (0 holds the module) |
| en_wr | input | 1 | Strobe: the enable bit is being written |
| en_wdata | input | 1 | Value written to the enable bit |
| tx_data_wr | input | 1 | Strobe: a transmit data register is being written |
| shift_load | input | 1 | Pulse: a word moved into the shift register |
| ev_rx_full | input | 1 | Pulse: receive buffer filled |
| ev_rx_ovr | input | 1 | Pulse: receive overrun |
| ev_bit_err | input | 1 | Pulse: bit error |
| ev_desync | input | 1 | Pulse: desynchronisation |
| ev_par_err | input | 1 | Pulse: parity error |
| ev_timeout | input | 1 | Pulse: timeout |
| ev_dlen_err | input | 1 | Pulse: data-length error |
| irq_en | input | 32 | Per-bit interrupt enables |
| irq | output | 1 | Combined interrupt request |
| ram_we | output | 1 | Buffer RAM initialisation write enable |
| ram_addr | output | ADDR_W | Buffer RAM initialisation address |
| init_done | output | 1 | One-cycle pulse at the end of initialisation |

## Verification
The bench builds the block with DEPTH=5, which gives a 3-bit address. A complete initialisation walk, a mid-walk abort and the restart each take only a few cycles and can be checked cycle by cycle. At that size, every write-1-to-clear bit can be swept through all eight combinations of prior value, event and clear. Every one of the 32 write-data positions and every one of the 32 interrupt-enable positions is also driven singly, with the expected word and interrupt level computed from bit masks.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned BIT_BUSY = 24;
    localparam int unsigned BIT_TXE  = 9;
    localparam int unsigned BIT_RXF  = 8;
    localparam int unsigned BIT_OVR  = 6;
    localparam int unsigned BIT_BERR = 4;
    localparam int unsigned BIT_DSYN = 3;
    localparam int unsigned BIT_PAR  = 2;
    localparam int unsigned BIT_TMO  = 1;
    localparam int unsigned BIT_DLEN = 0;

    // Bits cleared by writing 1
    localparam logic [WORD_W-1:0] W1C_MASK =
        (32'd1 << BIT_RXF) | (32'd1 << BIT_OVR) | (32'd1 << BIT_BERR) |
        (32'd1 << BIT_DSYN) | (32'd1 << BIT_PAR) | (32'd1 << BIT_TMO) |
        (32'd1 << BIT_DLEN);

    // Bits that can raise the interrupt request
    localparam logic [WORD_W-1:0] IRQ_MASK = W1C_MASK | (32'd1 << BIT_TXE);

    typedef enum logic [1:0] {
        S_HELD   = 2'd0,
        S_WALK   = 2'd1,
        S_FINISH = 2'd2,
        S_READY  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/ssf_init_seq.sv
module ssf_init_seq
    import ssf_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swrst_ctl,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              init_done,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] cnt_q, cnt_d;

    // Next-state and counter decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!swrst_ctl) begin
            state_d = S_HELD;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                S_HELD: begin
                    state_d = S_WALK;
                    cnt_d   = '0;
                end
                S_WALK: begin
                    if (cnt_q == LAST_ADDR) begin
                        state_d = S_FINISH;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                S_FINISH: state_d = S_READY;
                S_READY:  state_d = S_READY;
                default:  state_d = S_HELD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_HELD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        ram_we    = 1'b0;
        init_done = 1'b0;
        unique case (state_q)
            S_HELD:   ;
            S_WALK:   ram_we = 1'b1;
            S_FINISH: init_done = 1'b1;
            S_READY:  ;
            default:  ;
        endcase
        ram_addr = cnt_q;
        busy     = !swrst_ctl || (state_q != S_READY);
    end

endmodule

// File: rtl/ssf_flag_cell.sv
module ssf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Set has priority so no event is lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/ssf_flag_bank.sv
module ssf_flag_bank
    import ssf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] ev_vec,
    input  logic              shift_load,
    input  logic              tx_data_wr,
    input  logic              en_wr,
    input  logic              en_wdata,
    output logic [WORD_W-1:0] flags
);

    logic txe_clr;
    assign txe_clr = tx_data_wr || (en_wr && !en_wdata);

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (W1C_MASK[i]) begin : g_w1c
            ssf_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (ev_vec[i]),
                .clr_i  (bus_wr && bus_wdata[i]),
                .flag_o (flags[i])
            );
        end else if (i == BIT_TXE) begin : g_txe
            ssf_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (shift_load),
                .clr_i  (txe_clr),
                .flag_o (flags[i])
            );
        end else begin : g_none
            assign flags[i] = 1'b0;
        end
    end

endmodule

// File: rtl/ssf_irq_merge.sv
module ssf_irq_merge
    import ssf_pkg::*;
(
    input  logic [WORD_W-1:0] flags,
    input  logic [WORD_W-1:0] irq_en,
    output logic              irq
);

    assign irq = |(flags & irq_en & IRQ_MASK);

endmodule

// File: rtl/ssf_status_reg.sv
module ssf_status_reg
    import ssf_pkg::*;
#(
    parameter  int DEPTH  = 256,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              swrst_ctl,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              tx_data_wr,
    input  logic              shift_load,
    input  logic              ev_rx_full,
    input  logic              ev_rx_ovr,
    input  logic              ev_bit_err,
    input  logic              ev_desync,
    input  logic              ev_par_err,
    input  logic              ev_timeout,
    input  logic              ev_dlen_err,
    input  logic [31:0]       irq_en,
    output logic              irq,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              init_done
);

    logic [WORD_W-1:0] ev_vec;
    logic [WORD_W-1:0] flags;
    logic              busy;

    always_comb begin
        ev_vec           = '0;
        ev_vec[BIT_RXF]  = ev_rx_full;
        ev_vec[BIT_OVR]  = ev_rx_ovr;
        ev_vec[BIT_BERR] = ev_bit_err;
        ev_vec[BIT_DSYN] = ev_desync;
        ev_vec[BIT_PAR]  = ev_par_err;
        ev_vec[BIT_TMO]  = ev_timeout;
        ev_vec[BIT_DLEN] = ev_dlen_err;
    end

    ssf_init_seq #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .swrst_ctl (swrst_ctl),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .init_done (init_done),
        .busy      (busy)
    );

    ssf_flag_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .ev_vec     (ev_vec),
        .shift_load (shift_load),
        .tx_data_wr (tx_data_wr),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .flags      (flags)
    );

    ssf_irq_merge u_irq (
        .flags  (flags),
        .irq_en (irq_en),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata           = flags;
        bus_rdata[BIT_BUSY] = busy;
    end

endmodule

// File: rtl/ssf_status_chk.sv
module ssf_status_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              swrst_ctl,
    input logic [31:0]       bus_rdata,
    input logic              shift_load,
    input logic              tx_data_wr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              ev_rx_ovr,
    input logic              ev_dlen_err,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              init_done
);

    p_busy_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !swrst_ctl |-> bus_rdata[24]);

    p_we_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (bus_rdata[24] && !init_done));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));

    p_done_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (!bus_rdata[24] || !swrst_ctl));

    p_walk_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we) |-> (ram_addr == '0));

    p_dlen_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata[0] && !ev_dlen_err) |=> !bus_rdata[0]);

    p_ovr_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_ovr |=> bus_rdata[6]);

    p_txe_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_data_wr && !shift_load) |=> !bus_rdata[9]);

    p_txe_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load |=> bus_rdata[9]);

endmodule

bind ssf_status_reg ssf_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .swrst_ctl   (swrst_ctl),
    .bus_rdata   (bus_rdata),
    .shift_load  (shift_load),
    .tx_data_wr  (tx_data_wr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .ev_rx_ovr   (ev_rx_ovr),
    .ev_dlen_err (ev_dlen_err),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .init_done   (init_done)
);

// File: tb/tb_ssf_status_reg.sv
module tb_ssf_status_reg;

    localparam int DEPTH = 5;
    localparam int AW    = 3;
    localparam logic [31:0] W1C = 32'h0000_015F;
    localparam logic [31:0] ALLF = 32'h0000_035F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          swrst_ctl = 1'b0;
    logic          en_wr = 1'b0, en_wdata = 1'b0, tx_data_wr = 1'b0, shift_load = 1'b0;
    logic          ev_rx_full = 0, ev_rx_ovr = 0, ev_bit_err = 0, ev_desync = 0;
    logic          ev_par_err = 0, ev_timeout = 0, ev_dlen_err = 0;
    logic [31:0]   irq_en = '0;
    logic          irq, ram_we, init_done;
    logic [AW-1:0] ram_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ssf_status_reg #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .swrst_ctl(swrst_ctl), .en_wr(en_wr),
        .en_wdata(en_wdata), .tx_data_wr(tx_data_wr), .shift_load(shift_load),
        .ev_rx_full(ev_rx_full), .ev_rx_ovr(ev_rx_ovr), .ev_bit_err(ev_bit_err),
        .ev_desync(ev_desync), .ev_par_err(ev_par_err), .ev_timeout(ev_timeout),
        .ev_dlen_err(ev_dlen_err), .irq_en(irq_en), .irq(irq), .ram_we(ram_we),
        .ram_addr(ram_addr), .init_done(init_done)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ev(input int p, input logic v);
        case (p)
            8: ev_rx_full = v;
            6: ev_rx_ovr = v;
            4: ev_bit_err = v;
            3: ev_desync = v;
            2: ev_par_err = v;
            1: ev_timeout = v;
            0: ev_dlen_err = v;
            default: ;
        endcase
    endtask

    task automatic clear_all();
        bus_wr = 1; bus_wdata = '1; tx_data_wr = 1;
        step();
        bus_wr = 0; bus_wdata = '0; tx_data_wr = 0;
    endtask

    task automatic set_all();
        for (int p = 0; p < 9; p++) set_ev(p, 1'b1);
        shift_load = 1;
        step();
        for (int p = 0; p < 9; p++) set_ev(p, 1'b0);
        shift_load = 0;
    endtask

    // Walks through a full initialisation; swrst_ctl must be 0 on entry
    task automatic full_walk(input string req);
        swrst_ctl = 1;
        for (int c = 1; c <= DEPTH; c++) begin
            step();
            chk({30'd0, ram_we, init_done}, 32'd2, req);
            chk(32'(ram_addr), 32'(c - 1), req);
        end
        step();
        chk({29'd0, ram_we, init_done, bus_rdata[24]}, 32'd3, req);
        step();
        chk({30'd0, init_done, bus_rdata[24]}, 32'd0, req);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        // R1 / R2: reset state with module held
        chk(bus_rdata, 32'h0100_0000, "R1");
        chk({31'd0, irq}, 32'd0, "R1");
        chk({31'd0, ram_we}, 32'd0, "R2");

        // R3: complete walk
        full_walk("R3");

        // R2: dropping control raises busy at once
        swrst_ctl = 0;
        #1;
        chk({31'd0, bus_rdata[24]}, 32'd1, "R2");
        step();
        chk({31'd0, ram_we}, 32'd0, "R2");

        // R4: abort mid-walk and restart
        swrst_ctl = 1;
        repeat (3) step();
        chk({31'd0, ram_we}, 32'd1, "R4");
        chk(32'(ram_addr), 32'd2, "R4");
        swrst_ctl = 0;
        #1;
        chk({31'd0, bus_rdata[24]}, 32'd1, "R4");
        step();
        chk({31'd0, ram_we}, 32'd0, "R4");
        full_walk("R4");

        // R5 / R6: every write-1-to-clear bit, all prior/event/clear combinations
        for (int p = 0; p < 32; p++) begin
            if (W1C[p]) begin
                for (int k = 0; k < 8; k++) begin
                    logic pv, ev, cl;
                    logic [31:0] exp;
                    pv = k[2]; ev = k[1]; cl = k[0];
                    clear_all();
                    if (pv) begin
                        set_ev(p, 1'b1);
                        step();
                        set_ev(p, 1'b0);
                    end
                    set_ev(p, ev);
                    bus_wr = 1;
                    bus_wdata = cl ? (32'd1 << p) : 32'd0;
                    step();
                    set_ev(p, 1'b0);
                    bus_wr = 0;
                    bus_wdata = '0;
                    exp = (ev || (pv && !cl)) ? (32'd1 << p) : 32'd0;
                    chk(bus_rdata, exp, (ev && cl) ? "R6" : "R5");
                end
            end
        end

        // R9 / R5: single-bit writes across all 32 positions with all flags set
        for (int p = 0; p < 32; p++) begin
            logic [31:0] bit_p;
            bit_p = 32'd1 << p;
            set_all();
            bus_wr = 1;
            bus_wdata = bit_p;
            step();
            bus_wr = 0;
            bus_wdata = '0;
            chk(bus_rdata, ALLF & ~(W1C & bit_p), W1C[p] ? "R5" : "R9");
        end

        // R7 / R8: transmit-empty flag
        clear_all();
        shift_load = 1; step(); shift_load = 0;
        chk(bus_rdata, 32'h200, "R7 set");
        tx_data_wr = 1; step(); tx_data_wr = 0;
        chk(bus_rdata, 32'h0, "R7 data write");
        shift_load = 1; step(); shift_load = 0;
        en_wr = 1; en_wdata = 1; step(); en_wr = 0; en_wdata = 0;
        chk(bus_rdata, 32'h200, "R7 enable 1");
        en_wr = 1; en_wdata = 0; step(); en_wr = 0;
        chk(bus_rdata, 32'h0, "R7 enable 0");
        shift_load = 1; step(); shift_load = 0;
        bus_wr = 1; bus_wdata = 32'h200; step(); bus_wr = 0; bus_wdata = '0;
        chk(bus_rdata, 32'h200, "R7 bus write");
        tx_data_wr = 1; shift_load = 1; step(); tx_data_wr = 0; shift_load = 0;
        chk(bus_rdata, 32'h200, "R8 data write");
        tx_data_wr = 1; step(); tx_data_wr = 0;
        en_wr = 1; en_wdata = 0; shift_load = 1; step(); en_wr = 0; shift_load = 0;
        chk(bus_rdata, 32'h200, "R8 enable 0");

        // R10: interrupt gating, every enable position
        set_all();
        for (int p = 0; p < 32; p++) begin
            irq_en = 32'd1 << p;
            #1;
            chk({31'd0, irq}, {31'd0, ALLF[p]}, "R10");
        end
        clear_all();
        irq_en = '1;
        #1;
        chk({31'd0, irq}, 32'd0, "R10 clear");
        for (int p = 0; p < 32; p++) begin
            if (W1C[p]) begin
                set_ev(p, 1'b1); step(); set_ev(p, 1'b0);
                irq_en = ~(32'd1 << p);
                #1;
                chk({31'd0, irq}, 32'd0, "R10 masked");
                irq_en = 32'd1 << p;
                #1;
                chk({31'd0, irq}, 32'd1, "R10 enabled");
                clear_all();
            end
        end
        irq_en = '0;

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule